// File: doc/BRIEF.md
# Conversion Result Holder with Ready Flag

This block keeps the most recent 24-bit conversion word, tag bits included, so that a serial port can shift it out. A strobe from the decimation filter offers each new word. A pair of pulses from the serial side marks where a read of the result begins and where it ends. The block drives a ready status bit and an active-low interrupt line. It decides when a word is presented as ready and when that status is withdrawn.

Every incoming word first goes into a one-word shadow stage. From there it moves into the visible result register only when that register holds nothing unread and no read is under way. Three cases follow from this rule:

- **Unread word.** If an unread word is about to be replaced, ready drops for one cycle before the new word appears. An edge-triggered interrupt therefore sees a fresh falling edge.
- **Word arriving during a read.** It waits in the shadow stage until the read has finished, so the word being shifted out never changes.
- **Sync input.** It has no effect on the flag or the data. A completed read still clears the flag while sync is high.

Top module: `rdy_result_hold`

## Requirements
- R1: While the reset is asserted, and after it, until the first result arrives, ready_o is 0, irq_n_o is 1 and rd_data_o is zero.
- R2: A strobe on res_valid_i while ready_o is 0 and no read is open makes the word visible on rd_data_o, with ready_o at 1, at the second rising edge after the strobe.
- R3: A pulse on rd_done_i clears ready_o at the next rising edge, whatever else happens in that cycle.
- R4: A strobe that arrives while ready_o is 1 and no read is open keeps the old word. ready_o falls at the second edge and returns to 1, with the new word, at the third edge. The low period is exactly one cycle.
- R5: sync_i has no effect on ready_o or rd_data_o.
- R6: A pulse on rd_done_i clears ready_o even while sync_i is 1.
- R7: From the edge that samples rd_start_i until the edge after rd_done_i, rd_data_o does not change. A word that arrives in that window is loaded, with ready_o at 1, at the second edge after rd_done_i.
- R8: irq_n_o is always the inverse of ready_o.
- R9: When several words arrive before a load can take place, only the last of them is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| res_valid_i | input | 1 | One-cycle strobe: a new conversion word is on res_word_i |
| res_word_i | input | 24 | Conversion word including tag bits |
| rd_start_i | input | 1 | One-cycle pulse: the serial port begins reading the result |
| rd_done_i | input | 1 | One-cycle pulse: the serial port finished reading the result |
| sync_i | input | 1 | Sync input; leaves flag and data untouched |
| rd_data_o | output | 24 | Visible result word |
| ready_o | output | 1 | Ready status bit, 1 when an unread word is present |
| irq_n_o | output | 1 | Active-low interrupt, low while ready |

## Verification
The result path is driven with four kinds of pattern:

- **Strobe into an empty register.** This confirms the plain two-edge load.
- **Strobe onto an unread word.** This separates a design that overwrites in place from one that opens the one-cycle gap.
- **Strobes inside an open read, single and back to back.** These show whether the visible word is protected and whether the latest word wins.
- **Reads with sync high and low.** These separate a flag that sync clears from one that only a completed read clears.

Words with all ones and alternating bits expose stuck or swapped data bits.

// File: rtl/drdy_pkg.sv
package drdy_pkg;
  localparam int unsigned RES_W = 24;
  localparam int unsigned RST_STAGES = 2;
  typedef logic [RES_W-1:0] res_word_t;
endpackage

// File: rtl/rdy_rst_sync.sv
module rdy_rst_sync #(
  parameter int unsigned STAGES = drdy_pkg::RST_STAGES
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  localparam int unsigned LAST = STAGES - 1;
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = chain_q[LAST];
endmodule

// File: rtl/rdy_shadow.sv
module rdy_shadow #(
  parameter int unsigned W = drdy_pkg::RES_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] word_i,
  input  logic         take_i,
  output logic         full_o,
  output logic [W-1:0] word_o
);
  logic         full_q, full_d;
  logic [W-1:0] word_q;

  always_comb begin
    full_d = full_q;
    if (take_i) full_d = 1'b0;
    if (wr_i)   full_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full_q <= 1'b0;
    else        full_q <= full_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    word_q <= '0;
    else if (wr_i) word_q <= word_i;
  end

  assign full_o = full_q;
  assign word_o = word_q;

  // R9: a write while full replaces the held word
  a_r9_latest_kept: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (full_o && word_o == $past(word_i)));
endmodule

// File: rtl/rdy_ctrl.sv
module rdy_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic full_i,
  input  logic rd_start_i,
  input  logic rd_done_i,
  output logic load_o,
  output logic reading_o,
  output logic ready_o,
  output logic irq_n_o
);
  logic ready_q, ready_d;
  logic reading_q, reading_d;
  logic irq_n_q;
  logic load_en, withdraw;

  always_comb begin
    load_en  = full_i & ~ready_q & ~reading_q & ~rd_start_i & ~rd_done_i;
    withdraw = full_i & ready_q & ~reading_q & ~rd_start_i;

    ready_d = ready_q;
    if (rd_done_i)     ready_d = 1'b0;
    else if (load_en)  ready_d = 1'b1;
    else if (withdraw) ready_d = 1'b0;

    reading_d = reading_q;
    if (rd_done_i)       reading_d = 1'b0;
    else if (rd_start_i) reading_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q   <= 1'b0;
      reading_q <= 1'b0;
      irq_n_q   <= 1'b1;
    end else begin
      ready_q   <= ready_d;
      reading_q <= reading_d;
      irq_n_q   <= ~ready_d;
    end
  end

  assign load_o    = load_en;
  assign reading_o = reading_q;
  assign ready_o   = ready_q;
  assign irq_n_o   = irq_n_q;

  // R3: a finished read clears the flag
  a_r3_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done_i |=> !ready_o);
  // R4: the withdraw gap lasts one cycle when nothing else intervenes
  a_r4_gap_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ready_q) && full_i && !reading_q && !rd_start_i && !rd_done_i) |=> ready_q);
  // R8: interrupt line mirrors the flag
  a_r8_irq_inverse: assert property (@(posedge clk) disable iff (!rst_n)
    irq_n_q == !ready_q);
endmodule

// File: rtl/rdy_result_reg.sv
module rdy_result_reg #(
  parameter int unsigned W = drdy_pkg::RES_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] word_i,
  output logic [W-1:0] data_o
);
  logic [W-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      data_q <= '0;
    else if (load_i) data_q <= word_i;
  end

  assign data_o = data_q;

  // R2: a load presents the shadow word on the next cycle
  a_r2_load_visible: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> data_o == $past(word_i));
endmodule

// File: rtl/rdy_result_hold.sv
module rdy_result_hold #(
  parameter int unsigned W = drdy_pkg::RES_W
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic         res_valid_i,
  input  logic [W-1:0] res_word_i,
  input  logic         rd_start_i,
  input  logic         rd_done_i,
  input  logic         sync_i,
  output logic [W-1:0] rd_data_o,
  output logic         ready_o,
  output logic         irq_n_o
);
  logic         rst_n;
  logic         shadow_full, load, reading;
  logic [W-1:0] shadow_word;

  rdy_rst_sync u_rst (
    .clk(clk), .arst_n(arst_n), .rst_n_o(rst_n)
  );

  rdy_shadow #(.W(W)) u_shadow (
    .clk(clk), .rst_n(rst_n), .wr_i(res_valid_i), .word_i(res_word_i),
    .take_i(load), .full_o(shadow_full), .word_o(shadow_word)
  );

  rdy_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .full_i(shadow_full), .rd_start_i(rd_start_i),
    .rd_done_i(rd_done_i), .load_o(load), .reading_o(reading),
    .ready_o(ready_o), .irq_n_o(irq_n_o)
  );

  rdy_result_reg #(.W(W)) u_res (
    .clk(clk), .rst_n(rst_n), .load_i(load), .word_i(shadow_word),
    .data_o(rd_data_o)
  );

  // R5: sync alone never drops the flag
  a_r5_sync_keeps_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_i && ready_o && !rd_done_i && !shadow_full) |=> ready_o);
  // R7: the visible word holds still while a read is open
  a_r7_stable_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    reading |=> $stable(rd_data_o));
endmodule

// File: tb/rdy_result_hold_tb_top.sv
module rdy_result_hold_tb_top;
  typedef struct packed {
    logic        v;
    logic [23:0] w;
    logic        rs;
    logic        rd;
    logic        sy;
    logic        er;
    logic [23:0] ed;
  } vec_t;

  localparam int NV = 29;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 24'h123456, 1'b0, 1'b0, 1'b0, 1'b0, 24'h000000}, // R1 nothing yet
    '{1'b0, 24'h0,      1'b0, 1'b0, 1'b0, 1'b1, 24'h123456}, // R2
    '{1'b0, 24'h0,      1'b0, 1'b0, 1'b0, 1'b1, 24'h123456},
    '{1'b0, 24'h0,      1'b0, 1'b0, 1'b1, 1'b1, 24'h123456}, // R5
    '{1'b0, 24'h0,      1'b1, 1'b0, 1'b1, 1'b1, 24'h123456}, // R5
    '{1'b0, 24'h0,      1'b0, 1'b1, 1'b1, 1'b0, 24'h123456}, // R6
    '{1'b0, 24'h0,      1'b0, 1'b0, 1'b0, 1'b0, 24'h123456},
    '{1'b1, 24'hABCDEF, 1'b0, 1'b0, 1'b0, 1'b0, 24'h123456},
    '{1'b0, 24'h0,      1'b0, 1'b0, 1'b0, 1'b1, 24'hABCDEF}, // R2
    '{1'b1, 24'h00FF00, 1'b0, 1'b0, 1'b0, 1'b1, 24'hABCDEF}, // R4
    '{1'b0, 24'h0,      1'b0, 1'b0, 1'b0, 1'b0, 24'hABCDEF}, // R4 gap
    '{1'b0, 24'h0,      1'b0, 1'b0, 1'b0, 1'b1, 24'h00FF00}, // R4 reload
    '{1'b0, 24'h0,      1'b1, 1'b0, 1'b0, 1'b1, 24'h00FF00}, // R7
    '{1'b1, 24'h5A5A5A, 1'b0, 1'b0, 1'b0, 1'b1, 24'h00FF00}, // R7
    '{1'b0, 24'h0,      1'b0, 1'b0, 1'b0, 1'b1, 24'h00FF00}, // R7
    '{1'b0, 24'h0,      1'b0, 1'b1, 1'b0, 1'b0, 24'h00FF00}, // R3
    '{1'b0, 24'h0,      1'b0, 1'b0, 1'b0, 1'b1, 24'h5A5A5A}, // R7
    '{1'b0, 24'h0,      1'b1, 1'b0, 1'b0, 1'b1, 24'h5A5A5A},
    '{1'b0, 24'h0,      1'b0, 1'b1, 1'b0, 1'b0, 24'h5A5A5A}, // R3
    '{1'b0, 24'h0,      1'b0, 1'b0, 1'b0, 1'b0, 24'h5A5A5A},
    '{1'b1, 24'hFFFFFF, 1'b0, 1'b0, 1'b0, 1'b0, 24'h5A5A5A},
    '{1'b1, 24'hA5A5A5, 1'b0, 1'b0, 1'b0, 1'b1, 24'hFFFFFF}, // R2
    '{1'b0, 24'h0,      1'b0, 1'b0, 1'b0, 1'b0, 24'hFFFFFF}, // R4
    '{1'b0, 24'h0,      1'b0, 1'b0, 1'b0, 1'b1, 24'hA5A5A5}, // R4
    '{1'b0, 24'h0,      1'b1, 1'b0, 1'b0, 1'b1, 24'hA5A5A5},
    '{1'b1, 24'h111111, 1'b0, 1'b0, 1'b0, 1'b1, 24'hA5A5A5}, // R9
    '{1'b1, 24'h222222, 1'b0, 1'b0, 1'b0, 1'b1, 24'hA5A5A5}, // R9
    '{1'b0, 24'h0,      1'b0, 1'b1, 1'b0, 1'b0, 24'hA5A5A5},
    '{1'b0, 24'h0,      1'b0, 1'b0, 1'b0, 1'b1, 24'h222222}  // R9 latest
  };

  logic        clk = 1'b0;
  logic        arst_n = 1'b0;
  logic        res_valid_i = 1'b0;
  logic [23:0] res_word_i = '0;
  logic        rd_start_i = 1'b0;
  logic        rd_done_i = 1'b0;
  logic        sync_i = 1'b0;
  logic [23:0] rd_data_o;
  logic        ready_o, irq_n_o;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  rdy_result_hold dut_i (
    .clk(clk), .arst_n(arst_n), .res_valid_i(res_valid_i), .res_word_i(res_word_i),
    .rd_start_i(rd_start_i), .rd_done_i(rd_done_i), .sync_i(sync_i),
    .rd_data_o(rd_data_o), .ready_o(ready_o), .irq_n_o(irq_n_o)
  );

  task automatic check(string req, logic er, logic [23:0] ed);
    n_checks++;
    if (ready_o !== er || rd_data_o !== ed || irq_n_o !== ~er) begin
      n_fail++;
      $display("FAIL %s: ready=%b data=%h irq_n=%b expected ready=%b data=%h irq_n=%b",
               req, ready_o, rd_data_o, irq_n_o, er, ed, ~er);
    end
  endtask

  task automatic drive(logic v, logic [23:0] w, logic rs, logic rd, logic sy);
    @(negedge clk);
    res_valid_i = v; res_word_i = w; rd_start_i = rs; rd_done_i = rd; sync_i = sy;
    @(posedge clk);
    #2;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 check("R1 reset held", 1'b0, 24'h0);
    @(negedge clk) arst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2 check("R1 after release", 1'b0, 24'h0);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].v, VECS[i].w, VECS[i].rs, VECS[i].rd, VECS[i].sy);
      check($sformatf("R2-table step %0d (R3 R4 R5 R6 R7 R8 R9)", i),
            VECS[i].er, VECS[i].ed);
    end

    // R3: a read end with nothing ready leaves the flag low
    drive(1'b0, 24'h0, 1'b0, 1'b1, 1'b0); drive(1'b0, 24'h0, 1'b1, 1'b0, 1'b0);
    drive(1'b0, 24'h0, 1'b0, 1'b1, 1'b0);
    check("R3 idle read end", 1'b0, 24'h222222);
    drive(1'b0, 24'h0, 1'b0, 1'b0, 1'b0);

    // R5: sync high does not block a load
    drive(1'b1, 24'h0F0F0F, 1'b0, 1'b0, 1'b1);
    drive(1'b0, 24'h0, 1'b0, 1'b0, 1'b1);
    check("R5 load under sync", 1'b1, 24'h0F0F0F);
    drive(1'b0, 24'h0, 1'b0, 1'b0, 1'b0);
    check("R5 sync release", 1'b1, 24'h0F0F0F);

    // R1: asynchronous reset mid-run
    @(negedge clk) arst_n = 1'b0;
    #2 check("R1 async reset", 1'b0, 24'h0);
    drive(1'b1, 24'h777777, 1'b0, 1'b0, 1'b0);
    drive(1'b0, 24'h0, 1'b0, 1'b0, 1'b0);
    check("R1 strobe in reset ignored", 1'b0, 24'h0);
    @(negedge clk) arst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2 check("R1 release again", 1'b0, 24'h0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule